// File: doc/BRIEF.md
# Pin Interrupt Acceptance and EOI Engine

This block sits between a bank of interrupt pins and the fabric that carries interrupt messages to processors. It keeps, for each pin, a request bit (IRR), a remote-acknowledge bit (remote-IRR) and a redirection entry holding vector, delivery mode, destination, destination mode, polarity, trigger mode and mask. A pin event gives the pin's raw level. The block applies the pin's polarity, updates the request bit and decides whether the event earns a new delivery or is merged into one already outstanding. A merged event is reported as coalesced.

Pins that need service are sent one at a time, lowest pin first, as a delivery message on a valid/ready channel. When a level-triggered pin's message is accepted, its remote-IRR is set, and further requests on that pin are held back. An end-of-interrupt notice carries a vector. A level-type notice clears remote-IRR on every pin whose entry holds that vector, and it re-delivers any such pin that is unmasked and still requesting. Pin 0 is always sent in physical mode to a boot-processor identifier given on an input.

Top module: `irq_pin_engine`

## Requirements
- R1: The effective level of a pin event is the raw level XOR the entry's polarity bit (polarity 1 means active low). An effective level of 0 clears the pin's IRR, issues no delivery and is never coalesced.
- R2: An edge-triggered pin (trigger bit 0) with effective level 1 is serviced only if its IRR was clear before the event and it is not already awaiting service. Otherwise the event is coalesced.
- R3: A level-triggered pin (trigger bit 1) with effective level 1 is serviced only if its remote-IRR is clear and the pin is neither awaiting service nor has a message on the delivery channel. Otherwise the event is coalesced.
- R4: A coalesced event raises `coal_o` for exactly the cycle after the event, with `coal_pin_o` giving the pin.
- R5: Servicing a pin whose mask bit is 1 drops the service: no message is sent and nothing is reported as coalesced.
- R6: A serviced pin's message appears on `dlv_valid_o` in the second cycle after the event is sampled. It carries the entry's destination, vector, destination mode, trigger mode and delivery mode, with `dlv_level_o` = 1 and `dlv_shorthand_o` = 0.
- R7: A message is held unchanged while `dlv_ready_i` is low. When a level-triggered pin's message is accepted (valid and ready both high), that pin's remote-IRR is set.
- R8: A message for pin 0 always has destination mode 0 (physical) and the destination `boot_id_i`, whatever its entry holds.
- R9: A level-type EOI (`eoi_level_i` = 1) clears remote-IRR on every pin whose vector equals `eoi_vector_i`, and re-services each such pin that is unmasked with IRR still set. An edge-type EOI changes nothing.
- R10: When several pins await service, they are sent one per message, lowest index first. Every serviced request yields exactly one message.
- R11: After reset no message is pending and every entry is masked. Writing an entry replaces all of its fields and clears its remote-IRR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| cfg_we_i | input | 1 | Write a redirection entry |
| cfg_pin_i | input | PIN_W | Pin whose entry is written |
| cfg_vector_i | input | VEC_W | Entry vector |
| cfg_dmode_i | input | DMODE_W | Entry delivery mode |
| cfg_dest_mode_i | input | 1 | Entry destination mode (0 physical, 1 logical) |
| cfg_pol_i | input | 1 | Entry polarity (1 active low) |
| cfg_trig_i | input | 1 | Entry trigger mode (0 edge, 1 level) |
| cfg_mask_i | input | 1 | Entry mask (1 masked) |
| cfg_dest_i | input | DEST_W | Entry destination |
| boot_id_i | input | DEST_W | Boot-processor identifier used for pin 0 |
| req_valid_i | input | 1 | Pin event strobe |
| req_pin_i | input | PIN_W | Pin of the event |
| req_level_i | input | 1 | Raw level of the event |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | VEC_W | Vector of the EOI |
| eoi_level_i | input | 1 | EOI type (1 level, 0 edge) |
| coal_o | output | 1 | Coalesced event flag |
| coal_pin_o | output | PIN_W | Pin of the coalesced event |
| dlv_valid_o | output | 1 | Delivery message valid |
| dlv_ready_i | input | 1 | Delivery message accepted |
| dlv_pin_o | output | PIN_W | Source pin of the message |
| dlv_dest_o | output | DEST_W | Destination |
| dlv_vector_o | output | VEC_W | Vector |
| dlv_dest_mode_o | output | 1 | Destination mode |
| dlv_trig_o | output | 1 | Trigger mode |
| dlv_dmode_o | output | DMODE_W | Delivery mode |
| dlv_level_o | output | 1 | Level field of the message |
| dlv_shorthand_o | output | 2 | Shorthand field of the message |

## Verification
The bench aims at the merge rules. A repeated high event on an edge pin must be coalesced, and a design that ignored the old IRR would send a second message. A level pin must stay silent after acceptance until an EOI, and a design that skipped remote-IRR would deliver again, or would re-deliver after an edge-type EOI. It checks that an EOI with a shared vector re-delivers two pins in index order. It checks that an entry rewrite lets a held level request through again, that a masked pin sends nothing, and that pin 0 has its destination replaced. A stalled channel with three pins waiting shows that the message is held and that the order is lowest index first; a wrong arbiter or a message that changes during the stall would show up as a scoreboard mismatch.

// File: rtl/irqe_pkg.sv
package irqe_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int DMODE_W = 3;

  localparam logic TRIG_EDGE  = 1'b0;
  localparam logic TRIG_LEVEL = 1'b1;
  localparam logic DM_PHYS    = 1'b0;

  // Fields carried to the delivery channel
  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    logic               trig;
    logic               dest_mode;
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vector;
  } msg_t;

  // Full per-pin redirection entry
  typedef struct packed {
    msg_t msg;
    logic pol;
    logic mask;
  } redir_t;
endpackage

// File: rtl/irqe_pin_slot.sv
module irqe_pin_slot
  import irqe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we_i,
  input  redir_t           cfg_entry_i,
  input  logic             req_we_i,
  input  logic             req_raw_i,
  input  logic             eoi_valid_i,
  input  logic             eoi_level_i,
  input  logic [VEC_W-1:0] eoi_vector_i,
  input  logic             take_i,
  input  logic             acc_lvl_i,
  input  logic             inflight_i,
  output msg_t             msg_o,
  output logic             mask_o,
  output logic             pend_o,
  output logic             coal_o
);
  redir_t entry_q, entry_d;
  logic   irr_q, irr_d;
  logic   rirr_q, rirr_d;
  logic   pend_q, pend_d;
  logic   coal_q, coal_d;
  logic   eoi_hit;
  logic   eff_lvl;
  logic   svc_ok;

  assign eoi_hit = eoi_valid_i && eoi_level_i && (eoi_vector_i == entry_q.msg.vector);
  assign eff_lvl = req_raw_i ^ entry_q.pol;

  // Order inside a cycle: acceptance, EOI, pin event, entry write
  always_comb begin
    entry_d = entry_q;
    irr_d   = irr_q;
    rirr_d  = rirr_q;
    pend_d  = pend_q && !take_i;
    coal_d  = 1'b0;
    svc_ok  = 1'b0;
    if (acc_lvl_i) rirr_d = 1'b1;
    if (eoi_hit) begin
      rirr_d = 1'b0;
      if (!entry_q.mask && irr_q) pend_d = 1'b1;
    end
    if (req_we_i) begin
      if (!eff_lvl) begin
        irr_d = 1'b0;
      end else begin
        irr_d = 1'b1;
        if (entry_q.msg.trig == TRIG_LEVEL)
          svc_ok = !rirr_d && !pend_d && !inflight_i;
        else
          svc_ok = !irr_q && !pend_d;
        if (svc_ok) pend_d = 1'b1;
        else        coal_d = 1'b1;
      end
    end
    if (cfg_we_i) begin
      entry_d = cfg_entry_i;
      rirr_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q      <= '0;
      entry_q.mask <= 1'b1;
      irr_q        <= 1'b0;
      rirr_q       <= 1'b0;
      pend_q       <= 1'b0;
      coal_q       <= 1'b0;
    end else begin
      if (cfg_we_i) entry_q <= entry_d;
      if (req_we_i) irr_q   <= irr_d;
      rirr_q <= rirr_d;
      pend_q <= pend_d;
      coal_q <= coal_d;
    end
  end

  assign msg_o  = entry_q.msg;
  assign mask_o = entry_q.mask;
  assign pend_o = pend_q;
  assign coal_o = coal_q;

  assert_irr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we_i && !eff_lvl) |=> !irr_q);
  assert_coal_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    coal_q |-> $past(req_we_i));
  assert_rirr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lvl_i && !eoi_hit && !cfg_we_i) |=> rirr_q);
  assert_eoi_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !cfg_we_i) |=> !rirr_q);
  assert_write_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> !rirr_q);
endmodule

// File: rtl/irqe_prio_pick.sv
module irqe_prio_pick #(
  parameter int NUM_PINS = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [NUM_PINS-1:0] take_o,
  output logic [PIN_W-1:0]    idx_o,
  output logic                valid_o
);
  localparam logic [NUM_PINS-1:0] ONE = NUM_PINS'(1);

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        valid_o = 1'b1;
        idx_o   = PIN_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++)
      take_o[i] = en_i && valid_o && (idx_o == PIN_W'(i));
  end

  assert_one_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o));
  assert_lowest_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_o) |-> (((take_o - ONE) & pend_i) == '0));
endmodule

// File: rtl/irqe_dlv_out.sv
module irqe_dlv_out
  import irqe_pkg::*;
#(
  parameter int PIN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [PIN_W-1:0]  launch_pin_i,
  input  msg_t              msg_i,
  input  logic [DEST_W-1:0] boot_id_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [PIN_W-1:0]  pin_o,
  output msg_t              msg_o
);
  logic             valid_q, valid_d;
  logic [PIN_W-1:0] pin_q;
  msg_t             msg_q, msg_d;

  always_comb begin
    valid_d = valid_q;
    if (valid_q && ready_i) valid_d = 1'b0;
    if (launch_i)           valid_d = 1'b1;
    msg_d = msg_i;
    if (launch_pin_i == '0) begin
      msg_d.dest      = boot_id_i;
      msg_d.dest_mode = DM_PHYS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pin_q   <= '0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (launch_i) begin
        pin_q <= launch_pin_i;
        msg_q <= msg_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign pin_o   = pin_q;
  assign msg_o   = msg_q;

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(pin_o) && $stable(msg_o)));
  assert_pin0_phys_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && pin_o == '0) |-> (msg_o.dest_mode == DM_PHYS));
  assert_pin0_boot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(valid_o) && pin_o == '0) |-> (msg_o.dest == $past(boot_id_i)));
endmodule

// File: rtl/irq_pin_engine.sv
module irq_pin_engine
  import irqe_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we_i,
  input  logic [PIN_W-1:0]   cfg_pin_i,
  input  logic [VEC_W-1:0]   cfg_vector_i,
  input  logic [DMODE_W-1:0] cfg_dmode_i,
  input  logic               cfg_dest_mode_i,
  input  logic               cfg_pol_i,
  input  logic               cfg_trig_i,
  input  logic               cfg_mask_i,
  input  logic [DEST_W-1:0]  cfg_dest_i,
  input  logic [DEST_W-1:0]  boot_id_i,
  input  logic               req_valid_i,
  input  logic [PIN_W-1:0]   req_pin_i,
  input  logic               req_level_i,
  input  logic               eoi_valid_i,
  input  logic [VEC_W-1:0]   eoi_vector_i,
  input  logic               eoi_level_i,
  output logic               coal_o,
  output logic [PIN_W-1:0]   coal_pin_o,
  output logic               dlv_valid_o,
  input  logic               dlv_ready_i,
  output logic [PIN_W-1:0]   dlv_pin_o,
  output logic [DEST_W-1:0]  dlv_dest_o,
  output logic [VEC_W-1:0]   dlv_vector_o,
  output logic               dlv_dest_mode_o,
  output logic               dlv_trig_o,
  output logic [DMODE_W-1:0] dlv_dmode_o,
  output logic               dlv_level_o,
  output logic [1:0]         dlv_shorthand_o
);
  redir_t              cfg_entry;
  msg_t                msgs [NUM_PINS];
  logic [NUM_PINS-1:0] mask_vec;
  logic [NUM_PINS-1:0] pend_vec;
  logic [NUM_PINS-1:0] coal_vec;
  logic [NUM_PINS-1:0] take_vec;
  logic [PIN_W-1:0]    pick_idx;
  logic                pick_valid;
  logic                launch;
  logic                accept;
  msg_t                out_msg;

  assign cfg_entry.msg.dest      = cfg_dest_i;
  assign cfg_entry.msg.trig      = cfg_trig_i;
  assign cfg_entry.msg.dest_mode = cfg_dest_mode_i;
  assign cfg_entry.msg.dmode     = cfg_dmode_i;
  assign cfg_entry.msg.vector    = cfg_vector_i;
  assign cfg_entry.pol           = cfg_pol_i;
  assign cfg_entry.mask          = cfg_mask_i;

  assign accept = dlv_valid_o && dlv_ready_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_slot
    irqe_pin_slot u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we_i     (cfg_we_i && (cfg_pin_i == PIN_W'(i))),
      .cfg_entry_i  (cfg_entry),
      .req_we_i     (req_valid_i && (req_pin_i == PIN_W'(i))),
      .req_raw_i    (req_level_i),
      .eoi_valid_i  (eoi_valid_i),
      .eoi_level_i  (eoi_level_i),
      .eoi_vector_i (eoi_vector_i),
      .take_i       (take_vec[i]),
      .acc_lvl_i    (accept && (dlv_pin_o == PIN_W'(i)) && (dlv_trig_o == TRIG_LEVEL)),
      .inflight_i   (dlv_valid_o && (dlv_pin_o == PIN_W'(i))),
      .msg_o        (msgs[i]),
      .mask_o       (mask_vec[i]),
      .pend_o       (pend_vec[i]),
      .coal_o       (coal_vec[i])
    );
  end

  irqe_prio_pick #(.NUM_PINS(NUM_PINS)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (!dlv_valid_o),
    .pend_i  (pend_vec),
    .take_o  (take_vec),
    .idx_o   (pick_idx),
    .valid_o (pick_valid)
  );

  // A masked pick is consumed without a message
  assign launch = pick_valid && !dlv_valid_o && !mask_vec[pick_idx];

  irqe_dlv_out #(.PIN_W(PIN_W)) u_dlv (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch_i     (launch),
    .launch_pin_i (pick_idx),
    .msg_i        (msgs[pick_idx]),
    .boot_id_i    (boot_id_i),
    .ready_i      (dlv_ready_i),
    .valid_o      (dlv_valid_o),
    .pin_o        (dlv_pin_o),
    .msg_o        (out_msg)
  );

  assign dlv_dest_o      = out_msg.dest;
  assign dlv_vector_o    = out_msg.vector;
  assign dlv_dest_mode_o = out_msg.dest_mode;
  assign dlv_trig_o      = out_msg.trig;
  assign dlv_dmode_o     = out_msg.dmode;
  assign dlv_level_o     = 1'b1;
  assign dlv_shorthand_o = 2'b00;

  always_comb begin
    coal_pin_o = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (coal_vec[i]) coal_pin_o = PIN_W'(i);
  end
  assign coal_o = |coal_vec;

  assert_coal_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(coal_vec));
  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !dlv_valid_o && mask_vec[pick_idx]) |=> !dlv_valid_o);
endmodule

// File: tb/irq_pin_engine_bench.sv
module irq_pin_engine_bench;
  localparam int NP = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_dm, cfg_pol, cfg_trig, cfg_mask;
  logic [2:0] cfg_pin, cfg_dmode;
  logic [7:0] cfg_vec, cfg_dest, boot;
  logic       req_valid, req_level;
  logic [2:0] req_pin;
  logic       eoi_valid, eoi_level;
  logic [7:0] eoi_vec;
  logic       coal_o, dlv_valid, dlv_ready, dlv_dm, dlv_trig, dlv_level;
  logic [2:0] coal_pin, dlv_pin, dlv_dmode;
  logic [7:0] dlv_dest, dlv_vec;
  logic [1:0] dlv_sh;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  logic [7:0]  sh_vec [NP];
  logic [7:0]  sh_dest[NP];
  logic [2:0]  sh_dmode[NP];
  logic        sh_dm  [NP];
  logic        sh_trig[NP];

  always #5 clk = ~clk;

  irq_pin_engine u_irq_pin_engine (
    .clk(clk), .rst_n(rst_n),
    .cfg_we_i(cfg_we), .cfg_pin_i(cfg_pin), .cfg_vector_i(cfg_vec), .cfg_dmode_i(cfg_dmode),
    .cfg_dest_mode_i(cfg_dm), .cfg_pol_i(cfg_pol), .cfg_trig_i(cfg_trig), .cfg_mask_i(cfg_mask),
    .cfg_dest_i(cfg_dest), .boot_id_i(boot),
    .req_valid_i(req_valid), .req_pin_i(req_pin), .req_level_i(req_level),
    .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vec), .eoi_level_i(eoi_level),
    .coal_o(coal_o), .coal_pin_o(coal_pin),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready), .dlv_pin_o(dlv_pin),
    .dlv_dest_o(dlv_dest), .dlv_vector_o(dlv_vec), .dlv_dest_mode_o(dlv_dm),
    .dlv_trig_o(dlv_trig), .dlv_dmode_o(dlv_dmode), .dlv_level_o(dlv_level),
    .dlv_shorthand_o(dlv_sh)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) tick();
  endtask

  function automatic logic [23:0] exp_of(input int p);
    logic [7:0] d;
    logic       m;
    d = (p == 0) ? boot : sh_dest[p];
    m = (p == 0) ? 1'b0 : sh_dm[p];
    return {p[2:0], sh_trig[p], m, sh_dmode[p], sh_vec[p], d};
  endfunction

  task automatic push(input int p);
    exp_q.push_back(exp_of(p));
  endtask

  task automatic cfg(input int p, input logic [7:0] v, input logic [2:0] dmode, input logic dm,
                     input logic pol, input logic trig, input logic mask, input logic [7:0] dest);
    tick();
    cfg_we = 1'b1; cfg_pin = p[2:0]; cfg_vec = v; cfg_dmode = dmode; cfg_dm = dm;
    cfg_pol = pol; cfg_trig = trig; cfg_mask = mask; cfg_dest = dest;
    sh_vec[p] = v; sh_dmode[p] = dmode; sh_dm[p] = dm; sh_trig[p] = trig; sh_dest[p] = dest;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic req(input int p, input logic lvl, input logic exp_coal, input string tag);
    tick();
    req_valid = 1'b1; req_pin = p[2:0]; req_level = lvl;
    tick();
    req_valid = 1'b0;
    chk(coal_o == exp_coal && (!exp_coal || coal_pin == p[2:0]), tag,
        {28'd0, coal_o, coal_pin}, {28'd0, exp_coal, p[2:0]});
  endtask

  task automatic eoi(input logic [7:0] v, input logic lvl);
    tick();
    eoi_valid = 1'b1; eoi_vec = v; eoi_level = lvl;
    tick();
    eoi_valid = 1'b0;
  endtask

  // Scoreboard monitor: every accepted message must match the oldest expected item
  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      logic [23:0] got;
      got = {dlv_pin, dlv_trig, dlv_dm, dlv_dmode, dlv_vec, dlv_dest};
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected message", {8'd0, got}, 32'd0);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(got == e, "R6 message fields", {8'd0, got}, {8'd0, e});
      end
      chk(dlv_level == 1'b1 && dlv_sh == 2'b00, "R6 level/shorthand",
          {29'd0, dlv_level, dlv_sh}, 32'h4);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] snap;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_pin = '0; cfg_vec = '0; cfg_dmode = '0; cfg_dm = 1'b0;
    cfg_pol = 1'b0; cfg_trig = 1'b0; cfg_mask = 1'b0; cfg_dest = '0; boot = 8'h09;
    req_valid = 1'b0; req_pin = '0; req_level = 1'b0;
    eoi_valid = 1'b0; eoi_vec = '0; eoi_level = 1'b0; dlv_ready = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk(dlv_valid == 1'b0 && coal_o == 1'b0, "R11 reset idle", {30'd0, dlv_valid, coal_o}, 32'd0);

    // R11/R5: entries come out of reset masked, so this event sends nothing
    req(3, 1'b1, 1'b0, "R5 masked after reset");
    idle(4);
    req(3, 1'b0, 1'b0, "R1 clear pin3");

    cfg(0, 8'h30, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h33);
    cfg(1, 8'h31, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h11);
    cfg(2, 8'h42, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h22);
    cfg(3, 8'h43, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h03);
    cfg(4, 8'h50, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 8'h04);
    cfg(5, 8'h55, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05);
    cfg(6, 8'h50, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 8'h06);
    cfg(7, 8'h57, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h77);

    // R6 latency: idle one cycle after the sampling edge, valid in the next
    push(3);
    req(3, 1'b1, 1'b0, "R2 edge first rise");
    chk(dlv_valid == 1'b0, "R6 not yet valid", {31'd0, dlv_valid}, 32'd0);
    tick();
    chk(dlv_valid == 1'b1, "R6 valid after two edges", {31'd0, dlv_valid}, 32'd1);
    idle(3);

    // R2: second high without a low in between is merged
    req(3, 1'b1, 1'b1, "R2 repeat high coalesced");
    idle(3);
    req(3, 1'b0, 1'b0, "R1 low not coalesced");
    push(3);
    req(3, 1'b1, 1'b0, "R2 rise after low");
    idle(4);

    // R1 polarity: pin1 is active low
    req(1, 1'b1, 1'b0, "R1 inactive raw high");
    idle(3);
    push(1);
    req(1, 1'b0, 1'b0, "R1 active raw low");
    idle(3);
    req(1, 1'b0, 1'b1, "R2 active-low repeat coalesced");
    req(1, 1'b1, 1'b0, "R1 release pin1");
    idle(2);

    // R8: pin0 redirected to boot id, physical mode
    push(0);
    req(0, 1'b1, 1'b0, "R8 pin0 request");
    idle(4);

    // R3/R7/R9 level pin2
    push(2);
    req(2, 1'b1, 1'b0, "R3 level first");
    idle(4);
    req(2, 1'b1, 1'b1, "R3 remote-IRR blocks");
    eoi(8'h42, 1'b0);
    idle(4);
    req(2, 1'b1, 1'b1, "R9 edge-type EOI no effect");
    push(2);
    eoi(8'h42, 1'b1);
    idle(5);
    req(2, 1'b0, 1'b0, "R1 level pin low");
    eoi(8'h42, 1'b1);
    idle(5);
    push(2);
    req(2, 1'b1, 1'b0, "R9 EOI cleared remote-IRR");
    idle(4);

    // R11: rewriting the entry clears remote-IRR
    cfg(2, 8'h44, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h22);
    push(2);
    req(2, 1'b1, 1'b0, "R11 rewrite lets request through");
    idle(4);

    // R9/R10: shared vector, both pins re-delivered in index order
    push(4);
    req(4, 1'b1, 1'b0, "R3 pin4 level");
    idle(4);
    push(6);
    req(6, 1'b1, 1'b0, "R3 pin6 level");
    idle(4);
    push(4);
    push(6);
    eoi(8'h50, 1'b1);
    idle(6);

    // R5: masked pin sends nothing and is not coalesced
    req(5, 1'b1, 1'b0, "R5 masked no coalesce");
    idle(4);

    // R7/R10: stalled channel, three pins waiting
    req(3, 1'b0, 1'b0, "R1 clear pin3 again");
    dlv_ready = 1'b0;
    push(7);
    push(1);
    push(3);
    req(7, 1'b1, 1'b0, "R10 pin7 launches");
    req(3, 1'b1, 1'b0, "R10 pin3 waits");
    req(1, 1'b0, 1'b0, "R10 pin1 waits");
    snap = {dlv_pin, dlv_vec};
    idle(3);
    chk(dlv_valid == 1'b1 && {dlv_pin, dlv_vec} == snap, "R7 held during stall",
        {20'd0, dlv_valid, dlv_pin, dlv_vec}, {20'd0, 1'b1, snap});
    dlv_ready = 1'b1;
    idle(10);

    chk(exp_q.size() == 0, "R10 all expected messages seen", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule